// File: doc/BRIEF.md
# Relative Branch and Loop Unit

This block owns the program counter of a small sequencer and moves it for the control-transfer operations: plain and conditional relative branches, subroutine calls, returns and counted decrement-and-branch loops. The decoder in front of it presents one operation at a time. Each operation carries an operation class, a 4-bit condition selector, an 8-bit inline displacement, a 16-bit extension word, a precomputed condition-true bit and the current 16-bit loop counter value. The program counter held inside the block is taken to already point past the extension word when an operation is issued.

Calls and returns go through a stack port with a request/ready handshake. A call writes the return address to the word below the stack pointer. A return reads the word at the stack pointer. While that transfer is outstanding the block reports busy and ignores new operations. The new PC takes effect on the ready cycle. Loop operations hand the decremented counter back through a one-cycle write-back strobe.

Top module: `branch_loop_unit`

## Requirements
- R1: After reset the PC equals parameter RESET_PC, and busy, the stack request and the counter write strobe are all low.
- R2: Operation class 0 (branch) with condition 0 always jumps: the new PC is PC - 2 + offset. The PC is visible on the cycle after the issue edge.
- R3: The branch offset is the sign-extended inline byte when that byte is nonzero. When the byte is zero, the offset is the sign-extended 16-bit extension word.
- R4: A branch with condition 2 to 15 jumps as in R2 when the condition-true input is 1. Otherwise the PC becomes PC - 2.
- R5: A branch with condition 1 is a call. The block raises a stack write request whose address is stack pointer - 4 and whose data is the PC at issue. On the ready cycle the stack pointer drops by 4 and the PC becomes PC - 2 + offset.
- R6: Operation class 2 (return) raises a stack read request at the stack pointer address. On the ready cycle the PC loads the read data and the stack pointer rises by 4.
- R7: While a stack request is pending and ready is low, busy is high, the request address and data hold steady, and issued operations change nothing.
- R8: Operation class 1 (loop) with condition-true 1 leaves the PC unchanged and raises no counter write.
- R9: A loop with condition-true 0 pulses the counter write strobe for one cycle with counter - 1 (0 wraps to 0xFFFF). It jumps to PC - 2 + sign-extended extension word only when the counter before the decrement was nonzero; otherwise the PC is unchanged.
- R10: Operation class 3 changes neither the PC nor the stack nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | Operation presented this cycle |
| op_class | input | 2 | 0 branch, 1 loop, 2 return, 3 none |
| cond_sel | input | 4 | Condition selector (0 always, 1 call) |
| disp_byte | input | 8 | Inline displacement |
| ext_word | input | 16 | Extension word |
| cond_true | input | 1 | Evaluated condition |
| loop_count | input | 16 | Loop counter value before decrement |
| pc | output | 32 | Program counter |
| busy | output | 1 | Stack transfer outstanding |
| stk_req | output | 1 | Stack request |
| stk_write | output | 1 | 1 push, 0 pop |
| stk_addr | output | 32 | Stack word address |
| stk_wdata | output | 32 | Return address for a push |
| stk_ready | input | 1 | Stack transfer completes |
| stk_rdata | input | 32 | Popped value |
| cnt_we | output | 1 | Counter write-back strobe |
| cnt_wdata | output | 16 | Decremented counter |

## Verification
The bench builds the block with RESET_PC = 0x10 and RESET_SP = 0x8. Backward displacements then carry the PC through address zero, and the third nested call pushes the stack pointer below zero. Both wraps are reached within a few operations. The ready delay on the stack port varies from zero to several cycles, so operations issued while a request waits are tried against both short and long waits.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int PC_W   = 32;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int EXT_W  = 16;
  localparam int SLOT   = 4;
  localparam int BACK   = 2;

  typedef enum logic [1:0] {
    OP_BRANCH = 2'd0,
    OP_LOOP   = 2'd1,
    OP_RETURN = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  function automatic logic [PC_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
    return {{(PC_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [PC_W-1:0] sext_ext(input logic [EXT_W-1:0] w);
    return {{(PC_W-EXT_W){w[EXT_W-1]}}, w};
  endfunction

  function automatic logic [PC_W-1:0] pick_offset(input logic [BYTE_W-1:0] b,
                                                 input logic [EXT_W-1:0] w);
    return (b != '0) ? sext_byte(b) : sext_ext(w);
  endfunction

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] base,
                                                input logic [PC_W-1:0] off);
    return base - PC_W'(BACK) + off;
  endfunction
endpackage

// File: rtl/blu_decide.sv
module blu_decide
  import blu_pkg::*;
(
  input  logic [1:0]        op_class,
  input  logic [3:0]        cond_sel,
  input  logic [BYTE_W-1:0] disp_byte,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic              cond_true,
  input  logic [CNT_W-1:0]  loop_count,
  input  logic [PC_W-1:0]   pc_now,
  output logic              move_now,
  output logic [PC_W-1:0]   move_pc,
  output logic              want_push,
  output logic              want_pop,
  output logic [PC_W-1:0]   call_pc,
  output logic              dec_we,
  output logic [CNT_W-1:0]  dec_val
);
  logic [PC_W-1:0] br_off;
  assign br_off  = pick_offset(disp_byte, ext_word);
  assign call_pc = rel_target(pc_now, br_off);

  always_comb begin
    move_now  = 1'b0;
    move_pc   = pc_now;
    want_push = 1'b0;
    want_pop  = 1'b0;
    dec_we    = 1'b0;
    dec_val   = loop_count - CNT_W'(1);
    case (op_e'(op_class))
      OP_BRANCH: begin
        if (cond_sel == 4'd1) begin
          want_push = 1'b1;
        end else begin
          move_now = 1'b1;
          move_pc  = (cond_sel == 4'd0 || cond_true) ? call_pc
                                                     : pc_now - PC_W'(BACK);
        end
      end
      OP_LOOP: begin
        if (!cond_true) begin
          dec_we = 1'b1;
          if (loop_count != '0) begin
            move_now = 1'b1;
            move_pc  = rel_target(pc_now, sext_ext(ext_word));
          end
        end
      end
      OP_RETURN: want_pop = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/blu_stack.sv
module blu_stack
  import blu_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_SP = 32'h0000_8000
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_push,
  input  logic            start_pop,
  input  logic [PC_W-1:0] ret_addr,
  input  logic [PC_W-1:0] call_pc,
  input  logic            stk_ready,
  input  logic [PC_W-1:0] stk_rdata,
  output logic            stk_req,
  output logic            stk_write,
  output logic [PC_W-1:0] stk_addr,
  output logic [PC_W-1:0] stk_wdata,
  output logic            commit,
  output logic [PC_W-1:0] commit_pc
);
  logic [PC_W-1:0] sp_q;
  logic [PC_W-1:0] tgt_q;

  assign commit    = stk_req && stk_ready;
  assign commit_pc = stk_write ? tgt_q : stk_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q      <= RESET_SP;
      tgt_q     <= '0;
      stk_req   <= 1'b0;
      stk_write <= 1'b0;
      stk_addr  <= '0;
      stk_wdata <= '0;
    end else if (commit) begin
      stk_req <= 1'b0;
      sp_q    <= stk_write ? sp_q - PC_W'(SLOT) : sp_q + PC_W'(SLOT);
    end else if (!stk_req && start_push) begin
      stk_req   <= 1'b1;
      stk_write <= 1'b1;
      stk_addr  <= sp_q - PC_W'(SLOT);
      stk_wdata <= ret_addr;
      tgt_q     <= call_pc;
    end else if (!stk_req && start_pop) begin
      stk_req   <= 1'b1;
      stk_write <= 1'b0;
      stk_addr  <= sp_q;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_req && !stk_ready |=> stk_req && $stable(stk_addr) && $stable(stk_wdata) && $stable(stk_write));
  p_push_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit && stk_write |=> sp_q == $past(stk_addr));
  p_pop_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !stk_write |=> sp_q == $past(stk_addr) + PC_W'(SLOT));
endmodule

// File: rtl/blu_loop.sv
module blu_loop
  import blu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] dec_val,
  output logic             cnt_we,
  output logic [CNT_W-1:0] cnt_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_we    <= 1'b0;
      cnt_wdata <= '0;
    end else begin
      cnt_we <= fire;
      if (fire) cnt_wdata <= dec_val;
    end
  end

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !cnt_we || $past(fire));
endmodule

// File: rtl/branch_loop_unit.sv
module branch_loop_unit
  import blu_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000,
  parameter logic [PC_W-1:0] RESET_SP = 32'h0000_8000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [1:0]        op_class,
  input  logic [3:0]        cond_sel,
  input  logic [BYTE_W-1:0] disp_byte,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic              cond_true,
  input  logic [CNT_W-1:0]  loop_count,
  output logic [PC_W-1:0]   pc,
  output logic              busy,
  output logic              stk_req,
  output logic              stk_write,
  output logic [PC_W-1:0]   stk_addr,
  output logic [PC_W-1:0]   stk_wdata,
  input  logic              stk_ready,
  input  logic [PC_W-1:0]   stk_rdata,
  output logic              cnt_we,
  output logic [CNT_W-1:0]  cnt_wdata
);
  logic            accept;
  logic            move_now, want_push, want_pop, dec_we;
  logic [PC_W-1:0] move_pc, call_pc, commit_pc;
  logic [CNT_W-1:0] dec_val;
  logic            commit;
  logic [PC_W-1:0] pc_q;

  assign busy   = stk_req;
  assign accept = issue_valid && !busy;
  assign pc     = pc_q;

  blu_decide u_decide (
    .op_class(op_class), .cond_sel(cond_sel), .disp_byte(disp_byte),
    .ext_word(ext_word), .cond_true(cond_true), .loop_count(loop_count),
    .pc_now(pc_q), .move_now(move_now), .move_pc(move_pc),
    .want_push(want_push), .want_pop(want_pop), .call_pc(call_pc),
    .dec_we(dec_we), .dec_val(dec_val)
  );

  blu_stack #(.RESET_SP(RESET_SP)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .start_push(accept && want_push), .start_pop(accept && want_pop),
    .ret_addr(pc_q), .call_pc(call_pc),
    .stk_ready(stk_ready), .stk_rdata(stk_rdata),
    .stk_req(stk_req), .stk_write(stk_write), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .commit(commit), .commit_pc(commit_pc)
  );

  blu_loop u_loop (
    .clk(clk), .rst_n(rst_n), .fire(accept && dec_we), .dec_val(dec_val),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pc_q <= RESET_PC;
    else if (commit)            pc_q <= commit_pc;
    else if (accept && move_now) pc_q <= move_pc;
  end

  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !stk_ready |=> $stable(pc) && !cnt_we);
  p_notaken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_class == 2'd0 && cond_sel >= 4'd2 && !cond_true |=> pc == $past(pc) - 32'd2);
  p_loop_true_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_class == 2'd1 && cond_true |=> $stable(pc) && !cnt_we);
  p_loop_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_class == 2'd1 && !cond_true |=> cnt_we && cnt_wdata == $past(loop_count) - 16'd1);
  p_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_class == 2'd3 |=> $stable(pc) && !busy && !cnt_we);
  p_call_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_class == 2'd0 && cond_sel == 4'd1 |=> busy && stk_write && stk_wdata == $past(pc));
  p_ret_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_class == 2'd2 |=> busy && !stk_write);
endmodule

// File: tb/branch_loop_unit_bench.sv
module branch_loop_unit_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic issue_valid = 0;
  logic [1:0] op_class = 3;
  logic [3:0] cond_sel = 0;
  logic [7:0] disp_byte = 0;
  logic [15:0] ext_word = 0;
  logic cond_true = 0;
  logic [15:0] loop_count = 0;
  logic [31:0] pc;
  logic busy, stk_req, stk_write, cnt_we;
  logic [31:0] stk_addr, stk_wdata;
  logic stk_ready = 0;
  logic [31:0] stk_rdata = 0;
  logic [15:0] cnt_wdata;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] m_pc, m_sp;

  always #4 clk = ~clk;

  branch_loop_unit #(.RESET_PC(32'h10), .RESET_SP(32'h8)) u_branch_loop_unit (.*);

  function automatic logic [31:0] off_of(logic [7:0] b, logic [15:0] w);
    int v;
    v = (b != 0) ? int'($signed(b)) : int'($signed(w));
    return 32'(v);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] o, logic [3:0] c, logic [7:0] b, logic [15:0] w,
                       logic t, logic [15:0] n);
    @(negedge clk);
    op_class = o; cond_sel = c; disp_byte = b; ext_word = w; cond_true = t; loop_count = n;
    issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic plain(logic [1:0] o, logic [3:0] c, logic [7:0] b, logic [15:0] w,
                       logic t, logic [15:0] n);
    logic exp_we;
    exp_we = 0;
    if (o == 0) begin
      m_pc = (c == 0 || t) ? m_pc - 2 + off_of(b, w) : m_pc - 2;
    end else if (o == 1 && !t) begin
      exp_we = 1;
      if (n != 0) m_pc = m_pc - 2 + 32'(int'($signed(w)));
    end
    issue(o, c, b, w, t, n);
    chk(pc == m_pc, "R2 R3 R4 R8 R9 R10 pc", pc, m_pc);
    chk(cnt_we == exp_we, "R8 R9 R10 cnt_we", 32'(cnt_we), 32'(exp_we));
    if (exp_we) chk(cnt_wdata == n - 16'd1, "R9 cnt_wdata", 32'(cnt_wdata), 32'(n - 16'd1));
    chk(!busy, "R10 busy", 32'(busy), 0);
  endtask

  task automatic wait_stack(int dly, logic [31:0] rdata);
    logic [31:0] held;
    held = pc;
    for (int i = 0; i < dly; i++) begin
      issue(0, 0, 8'h20, 0, 1, 0);
      chk(pc == held && busy && stk_req, "R7 ignored while busy", pc, held);
    end
    @(negedge clk);
    stk_rdata = rdata; stk_ready = 1;
    @(negedge clk);
    stk_ready = 0;
  endtask

  task automatic do_call(logic [7:0] b, logic [15:0] w, int dly);
    logic [31:0] tgt;
    tgt = m_pc - 2 + off_of(b, w);
    issue(0, 1, b, w, 0, 0);
    chk(stk_req && stk_write && busy, "R5 push request", {stk_req, stk_write, busy}, 3'b111);
    chk(stk_addr == m_sp - 4, "R5 push addr", stk_addr, m_sp - 4);
    chk(stk_wdata == m_pc, "R5 push data", stk_wdata, m_pc);
    wait_stack(dly, 32'h0);
    m_sp = m_sp - 4; m_pc = tgt;
    chk(pc == m_pc, "R5 call pc", pc, m_pc);
    chk(!busy, "R5 busy drops", 32'(busy), 0);
  endtask

  task automatic do_ret(logic [31:0] v, int dly);
    issue(2, 0, 0, 0, 0, 0);
    chk(stk_req && !stk_write && busy, "R6 pop request", {stk_req, stk_write, busy}, 3'b101);
    chk(stk_addr == m_sp, "R6 pop addr", stk_addr, m_sp);
    wait_stack(dly, v);
    m_sp = m_sp + 4; m_pc = v;
    chk(pc == m_pc, "R6 return pc", pc, m_pc);
    chk(!busy, "R6 busy drops", 32'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pc = 32'h10; m_sp = 32'h8;
    repeat (2) @(negedge clk);
    chk(pc == 32'h10, "R1 reset pc", pc, 32'h10);
    chk(!busy && !stk_req && !cnt_we, "R1 reset ctrl", {busy, stk_req, cnt_we}, 0);
    rst_n = 1;
    // directed corners
    plain(0, 0, 8'h80, 16'h1234, 0, 0);   // R3 byte -128, wraps below zero
    plain(0, 0, 8'h00, 16'h8000, 0, 0);   // R3 zero byte selects ext
    plain(0, 0, 8'h00, 16'h7ffe, 0, 0);
    plain(0, 5, 8'h10, 0, 0, 0);          // R4 not taken
    plain(0, 14, 8'h10, 0, 1, 0);         // R4 taken
    plain(1, 3, 8'h55, 16'hfff0, 1, 16'd7);  // R8
    plain(1, 3, 8'h00, 16'hfff0, 0, 16'd0);  // R9 wrap, no branch
    plain(1, 3, 8'h00, 16'hfff0, 0, 16'd1);  // R9 branch
    plain(3, 1, 8'h44, 16'h4444, 0, 16'd9);  // R10
    do_call(8'h06, 0, 0);
    do_call(8'h00, 16'hff00, 3);
    do_call(8'hfe, 0, 1);                  // stack pointer wraps below zero
    do_ret(32'h0000_2222, 2);
    do_ret(32'h0000_3330, 0);
    do_ret(32'h0000_0010, 4);
    for (int k = 0; k < 60; k++) begin
      logic [1:0] o;
      int sel;
      sel = int'($urandom_range(0, 9));
      o = 2'($urandom_range(0, 3));
      if (sel == 0) do_call(8'($urandom), 16'($urandom), int'($urandom_range(0, 5)));
      else if (sel == 1) do_ret({$urandom} & 32'hffff_fffe, int'($urandom_range(0, 5)));
      else begin
        logic [3:0] c;
        c = 4'($urandom);
        if (o == 2) o = 1;
        if (o == 0 && c == 1) c = 0;
        plain(o, c, ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom), 16'($urandom),
              1'($urandom), ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom));
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule